// File: doc/BRIEF.md
# Multi-Channel DMA Control Register Bank

This block is the shared control and status register bank that sits in front of a group of DMA channel engines. Software reaches it through a simple single-cycle register bus. Each of the three control words can be written in three ways: through a plain view, where the written word replaces the register; through a set view, where each one bit sets the matching register bit; and through a clear view, where each one bit clears it. In the two alias views, zero bits change nothing. A fourth word holds per-channel reset requests. A one written to it makes a single-cycle reset pulse to that channel, and the word always reads back as zero.

The bank drives a run/stop clock-gate line and a reset line to each channel engine, plus two global burst options. It collects per-channel completion and error events from the engines and combines them with per-channel enables into one interrupt line. Software acknowledges a channel by clearing its completion bit and its error bit through the clear views. The register bus is a plain control interface with no back-pressure. A write takes effect at the clock edge where `bus_wr` is high, and read data is combinational from `bus_addr`. The event inputs are single-cycle strobes and are never stalled.

Word address `bus_addr[3:2]` selects the register: 0 is the gate/burst word, 1 is the completion/enable word, 2 is the error word and 3 is the channel-reset word. `bus_addr[1:0]` selects the view: 0 is plain, 1 is set, 2 is clear and 3 is inert. With the defaults NCH=8 and all field offsets at 16, the bit positions are as follows. In word 0, gate bits sit at 16+c, the memory-side 8-beat burst enable at bit 1 and the peripheral-side burst enable at bit 0. In word 1, completion bits sit at c and enable bits at 16+c. In word 2, error bits sit at c. In word 3, reset bits sit at 16+c.

Top module: `dmab_top`

## Requirements
- R1: After reset, word 0 reads 0x00FF0000 (all gate bits set, both burst options off), words 1 and 2 read zero, all chan_gate outputs are 1, and chan_reset, burst8_en, pburst_en and irq are all 0.
- R2: A write through the plain view (code 0) replaces the implemented bits of the register. Unimplemented positions read as zero: only 0x00FF0003 in word 0, 0x00FF00FF in word 1 and 0x000000FF in word 2 are implemented.
- R3: A write through the set view (code 1) sets the bits written as one and leaves every other bit unchanged.
- R4: A write through the clear view (code 2) clears the bits written as one and leaves every other bit unchanged. A write through view code 3 changes no register.
- R5: chan_gate[c] equals word 0 bit 16+c, burst8_en equals word 0 bit 1 and pburst_en equals word 0 bit 0, one cycle after the write edge.
- R6: A done_evt[c] strobe sets word 1 bit c, and an err_evt[c] strobe sets word 2 bit c. A hardware set wins over a software clear or plain write of that bit in the same cycle.
- R7: irq is high exactly when, for some channel c, completion bit c and enable bit c are both set, or error bit c is set.
- R8: A write of ones to word 3 through the plain or set view raises the matching chan_reset bits (word 3 bit 16+c) for exactly the next cycle. A write through the clear view raises none, and word 3 always reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 4 | Word address: register in [3:2], view in [1:0] |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data of the addressed register |
| done_evt | input | NCH | Per-channel completion strobe from the engines |
| err_evt | input | NCH | Per-channel error strobe from the engines |
| chan_gate | output | NCH | Per-channel clock gate, 1 stops the channel |
| chan_reset | output | NCH | Per-channel single-cycle reset pulse |
| burst8_en | output | 1 | Memory-side 8-beat burst enable |
| pburst_en | output | 1 | Peripheral-side burst enable |
| irq | output | 1 | Combined interrupt request |

## Verification
The main sweep steps through every register and every view code in turn, eight times over, with a pseudo-random data word each time. This tells the plain, set, clear and inert views apart, because each leaves a different value in a register that already holds a mix of ones and zeros. Implemented and unimplemented bits are told apart by the same sweep. Each event strobe is driven on one channel at a time, once on its own and once in the same cycle as an all-ones clear, which separates a hardware set that wins from one that loses. The reset word is written with patterns that exercise every channel through all three views, checking the pulse in the cycle after the write, its absence one cycle later, and its absence for the clear view.

// File: rtl/dmab_pkg.sv
package dmab_pkg;
  localparam int unsigned DW = 32;
  localparam int unsigned NREG = 4;
  localparam int unsigned RSEL_W = $clog2(NREG);

  typedef enum logic [1:0] {
    VW_PLAIN = 2'd0,
    VW_SET   = 2'd1,
    VW_CLR   = 2'd2,
    VW_NONE  = 2'd3
  } view_t;

  typedef enum logic [RSEL_W-1:0] {
    RG_GATE = 2'd0,
    RG_DONE = 2'd1,
    RG_ERR  = 2'd2,
    RG_RST  = 2'd3
  } rsel_t;

  // Mask of NCH ones placed at bit offset OFS
  function automatic logic [DW-1:0] field_mask(int unsigned nch, int unsigned ofs);
    logic [DW-1:0] m;
    m = '0;
    for (int unsigned i = 0; i < nch; i++) m[ofs+i] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/dmab_decode.sv
module dmab_decode
  import dmab_pkg::*;
(
  input  logic                 bus_wr,
  input  logic [3:0]           bus_addr,
  output logic [NREG-1:0]      reg_we,
  output view_t                wview,
  output logic [RSEL_W-1:0]    rsel
);
  assign rsel  = bus_addr[3:2];
  assign wview = view_t'(bus_addr[1:0]);

  // One write strobe per register word; inert view never strobes
  for (genvar r = 0; r < NREG; r++) begin : g_we
    assign reg_we[r] = bus_wr && (rsel == RSEL_W'(r)) && (wview != VW_NONE);
  end
endmodule

// File: rtl/dmab_reg.sv
module dmab_reg
  import dmab_pkg::*;
#(
  parameter logic [DW-1:0] IMPL  = '1,
  parameter logic [DW-1:0] RSTV  = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  view_t         wview,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] hw_set,
  output logic [DW-1:0] q
);
  logic [DW-1:0] sw_nxt;

  always_comb begin
    sw_nxt = q;
    if (we) begin
      case (wview)
        VW_PLAIN: sw_nxt = wdata;
        VW_SET:   sw_nxt = q | wdata;
        VW_CLR:   sw_nxt = q & ~wdata;
        default:  sw_nxt = q;
      endcase
    end
  end

  // Hardware set events are OR-ed after the software update: they win
  always_ff @(posedge clk) begin
    if (!rst_n) q <= RSTV & IMPL;
    else        q <= (sw_nxt | hw_set) & IMPL;
  end

  a_r6_hw_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|(hw_set & IMPL)) |=> ((q & $past(hw_set & IMPL)) == $past(hw_set & IMPL)));

  a_r3_set_view: assert property (@(posedge clk) disable iff (!rst_n)
    (we && wview == VW_SET) |=> ((q & $past(wdata & IMPL)) == $past(wdata & IMPL)));

  a_r4_clr_view: assert property (@(posedge clk) disable iff (!rst_n)
    (we && wview == VW_CLR) |=> ((q & $past(wdata & ~hw_set)) == '0));

  a_r4_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!we && hw_set == '0) |=> $stable(q));
endmodule

// File: rtl/dmab_pulse.sv
module dmab_pulse
  import dmab_pkg::*;
#(
  parameter int unsigned NCH = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           we,
  input  view_t          wview,
  input  logic [NCH-1:0] req,
  output logic [NCH-1:0] pulse
);
  logic fire;
  assign fire = we && (wview == VW_PLAIN || wview == VW_SET);

  // Self-clearing: held for exactly one cycle unless rewritten
  always_ff @(posedge clk) begin
    if (!rst_n)    pulse <= '0;
    else if (fire) pulse <= req;
    else           pulse <= '0;
  end

  a_r8_pulse_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (|pulse) |-> $past(fire));

  a_r8_pulse_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (!fire) |=> (pulse == '0));
endmodule

// File: rtl/dmab_top.sv
module dmab_top
  import dmab_pkg::*;
#(
  parameter int unsigned NCH      = 8,
  parameter int unsigned GATE_OFS = 16,
  parameter int unsigned IE_OFS   = 16,
  parameter int unsigned RST_OFS  = 16,
  parameter int unsigned B8_BIT   = 1,
  parameter int unsigned PB_BIT   = 0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_wr,
  input  logic [3:0]     bus_addr,
  input  logic [DW-1:0]  bus_wdata,
  output logic [DW-1:0]  bus_rdata,
  input  logic [NCH-1:0] done_evt,
  input  logic [NCH-1:0] err_evt,
  output logic [NCH-1:0] chan_gate,
  output logic [NCH-1:0] chan_reset,
  output logic           burst8_en,
  output logic           pburst_en,
  output logic           irq
);
  localparam logic [DW-1:0] GATE_M = field_mask(NCH, GATE_OFS);
  localparam logic [DW-1:0] STAT_M = field_mask(NCH, 0);
  localparam logic [DW-1:0] IE_M   = field_mask(NCH, IE_OFS);
  localparam logic [DW-1:0] OPT_M  = (DW'(1) << B8_BIT) | (DW'(1) << PB_BIT);
  localparam logic [DW-1:0] IMPL0  = GATE_M | OPT_M;
  localparam logic [DW-1:0] IMPL1  = STAT_M | IE_M;

  logic [NREG-1:0]   reg_we;
  view_t             wview;
  logic [RSEL_W-1:0] rsel;
  logic [DW-1:0]     q_gate, q_done, q_err;
  logic [DW-1:0]     set_done, set_err;

  dmab_decode u_dec (
    .bus_wr  (bus_wr),
    .bus_addr(bus_addr),
    .reg_we  (reg_we),
    .wview   (wview),
    .rsel    (rsel)
  );

  assign set_done = DW'(done_evt);
  assign set_err  = DW'(err_evt);

  dmab_reg #(.IMPL(IMPL0), .RSTV(GATE_M)) u_gate (
    .clk(clk), .rst_n(rst_n), .we(reg_we[RG_GATE]), .wview(wview),
    .wdata(bus_wdata), .hw_set('0), .q(q_gate));

  dmab_reg #(.IMPL(IMPL1), .RSTV('0)) u_done (
    .clk(clk), .rst_n(rst_n), .we(reg_we[RG_DONE]), .wview(wview),
    .wdata(bus_wdata), .hw_set(set_done), .q(q_done));

  dmab_reg #(.IMPL(STAT_M), .RSTV('0)) u_err (
    .clk(clk), .rst_n(rst_n), .we(reg_we[RG_ERR]), .wview(wview),
    .wdata(bus_wdata), .hw_set(set_err), .q(q_err));

  dmab_pulse #(.NCH(NCH)) u_rst (
    .clk(clk), .rst_n(rst_n), .we(reg_we[RG_RST]), .wview(wview),
    .req(bus_wdata[RST_OFS +: NCH]), .pulse(chan_reset));

  always_comb begin
    case (rsel)
      RG_GATE: bus_rdata = q_gate;
      RG_DONE: bus_rdata = q_done;
      RG_ERR:  bus_rdata = q_err;
      default: bus_rdata = '0;
    endcase
  end

  logic [NCH-1:0] ch_req;
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign chan_gate[c] = q_gate[GATE_OFS + c];
    assign ch_req[c]    = (q_done[c] & q_done[IE_OFS + c]) | q_err[c];
  end

  assign burst8_en = q_gate[B8_BIT];
  assign pburst_en = q_gate[PB_BIT];
  assign irq       = |ch_req;

  a_r7_err_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (|q_err[NCH-1:0]) |-> irq);

  a_r7_quiet_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (q_err[NCH-1:0] == '0 && q_done[NCH-1:0] == '0) |-> !irq);

  a_r5_gate_follows_plain: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we[RG_GATE] && wview == VW_PLAIN) |=> (chan_gate == $past(bus_wdata[GATE_OFS +: NCH])));
endmodule

// File: tb/sim_dmab_top.sv
module sim_dmab_top;
  localparam int NCH = 8;
  localparam logic [31:0] M0 = 32'h00FF0003;
  localparam logic [31:0] M1 = 32'h00FF00FF;
  localparam logic [31:0] M2 = 32'h000000FF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NCH-1:0] done_evt = '0, err_evt = '0;
  logic [NCH-1:0] chan_gate, chan_reset;
  logic burst8_en, pburst_en, irq;

  int n_chk = 0, n_bad = 0;
  logic [31:0] m0, m1, m2, seed;
  bit finished = 0;

  always #10 clk = ~clk;

  dmab_top u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .done_evt(done_evt),
    .err_evt(err_evt), .chan_gate(chan_gate), .chan_reset(chan_reset),
    .burst8_en(burst8_en), .pburst_en(pburst_en), .irq(irq));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] upd(logic [31:0] old, int v, logic [31:0] d, logic [31:0] m);
    case (v)
      0: return d & m;
      1: return (old | d) & m;
      2: return old & ~d & m;
      default: return old;
    endcase
  endfunction

  function automatic logic exp_irq();
    return (|(m1[7:0] & m1[23:16])) | (|m2[7:0]);
  endfunction

  task automatic wr(int r, int v, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 4'(r*4 + v); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(int r, output logic [31:0] d);
    bus_addr = 4'(r*4);
    #1 d = bus_rdata;
  endtask

  task automatic check_all(string tag);
    logic [31:0] d;
    rd(0, d); chk({tag, " word0"}, d, m0);
    rd(1, d); chk({tag, " word1"}, d, m1);
    rd(2, d); chk({tag, " word2"}, d, m2);
    rd(3, d); chk("R8 word3 reads zero", d, 32'h0);
    chk("R5 chan_gate", 32'(chan_gate), 32'(m0[23:16]));
    chk("R5 burst8_en", 32'(burst8_en), 32'(m0[1]));
    chk("R5 pburst_en", 32'(pburst_en), 32'(m0[0]));
    chk("R7 irq", 32'(irq), 32'(exp_irq()));
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_up();
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    m0 = 32'h00FF0000; m1 = 0; m2 = 0;
    check_all("R1 reset");
    chk("R1 chan_reset", 32'(chan_reset), 32'h0);

    // Sweep over all registers and views with pseudo-random data
    seed = 32'h1234_5678;
    for (int k = 0; k < 96; k++) begin
      int r, v;
      string tag;
      r = k % 3; v = (k / 3) % 4;
      seed ^= seed << 13; seed ^= seed >> 17; seed ^= seed << 5;
      wr(r, v, seed);
      case (r)
        0: m0 = upd(m0, v, seed, M0);
        1: m1 = upd(m1, v, seed, M1);
        default: m2 = upd(m2, v, seed, M2);
      endcase
      tag = (v == 0) ? "R2 plain" : (v == 1) ? "R3 set" : "R4 clr/inert";
      check_all(tag);
    end

    // Hardware events per channel, alone and against a same-cycle clear
    wr(1, 0, 32'h00FF0000); m1 = 32'h00FF0000;
    wr(2, 0, 32'h0); m2 = 0;
    for (int c = 0; c < NCH; c++) begin
      @(negedge clk);
      done_evt = NCH'(1) << c;
      @(negedge clk);
      done_evt = '0;
      m1 = m1 | (32'h1 << c);
      check_all("R6 done_evt alone");
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = 4'(1*4 + 2); bus_wdata = 32'h000000FF;
      done_evt = NCH'(1) << ((c + 1) % NCH);
      @(negedge clk);
      bus_wr = 1'b0; done_evt = '0;
      m1 = 32'h00FF0000 | (32'h1 << ((c + 1) % NCH));
      check_all("R6 done wins over clear");
      wr(1, 2, 32'h000000FF); m1 = 32'h00FF0000;
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = 4'(2*4 + 2); bus_wdata = 32'hFFFFFFFF;
      err_evt = NCH'(1) << c;
      @(negedge clk);
      bus_wr = 1'b0; err_evt = '0;
      m2 = 32'h1 << c;
      check_all("R6 err wins over clear");
      chk("R7 error drives irq", 32'(irq), 32'h1);
      wr(2, 2, 32'h000000FF); m2 = 0;
      check_all("R7 acknowledged");
    end

    // Channel reset pulses
    for (int p = 0; p < 12; p++) begin
      logic [7:0] pat;
      int v;
      pat = 8'((p < 8) ? (1 << p) : (8'hA5 ^ 8'(p * 37)));
      v = p % 3;
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = 4'(3*4 + v); bus_wdata = {8'h0, pat, 16'hFFFF};
      @(negedge clk);
      bus_wr = 1'b0;
      chk("R8 pulse in cycle after write", 32'(chan_reset), (v == 2) ? 32'h0 : 32'(pat));
      rd(3, d); chk("R8 word3 reads zero", d, 32'h0);
      @(negedge clk);
      chk("R8 pulse self-clears", 32'(chan_reset), 32'h0);
      check_all("R8 no side effect");
    end

    finish_up();
  end
endmodule